// File: doc/BRIEF.md
# Indirect Byte-Serial Memory Port

This peripheral lets a small host with an 8-bit register bus reach a large external RAM without giving up a wide slice of its own address map. The host loads a 24-bit pointer one byte at a time through three pointer registers. It then moves data through a single byte-wide data register. Every transfer through the data register touches the RAM byte the pointer names, then advances the pointer by one. A block of consecutive bytes can therefore be streamed with one pointer load followed by repeated data accesses.

The RAM side is a synchronous single-port interface. Read data is expected one clock after the read enable and must stay steady until the next read enable. The amount of RAM actually fitted is a parameter. Pointer values at or above that size still advance normally, but no RAM cycle is issued for them: reads return all ones and writes are dropped. Host read results appear on `host_rdata` in the cycle after the read strobe and stay there until the next read is accepted.

Register select codes: 0 is the data register, 1 is pointer bits 7:0, 2 is pointer bits 15:8 and 3 is pointer bits 23:16.

Top module: `indmem_port`

## Requirements
- R1: After reset the pointer is 0x000000 and `host_rdata` is 0x00.
- R2: A host write to select 1, 2 or 3 replaces only the matching pointer byte (bits 7:0, 15:8, 23:16). A read of that select returns the byte. Neither action moves the pointer.
- R3: A host write to select 0 drives `ram_we` high in that same cycle, with `ram_addr` equal to the pointer and `ram_wdata` equal to `host_wdata`. The pointer is one higher from the next cycle.
- R4: A host read of select 0 drives `ram_re` high in that same cycle, with `ram_addr` equal to the pointer. The next cycle `host_rdata` shows the RAM byte at the pre-increment pointer, and the pointer is one higher.
- R5: Advancing past 0xFF in bits 7:0 carries into bits 15:8, and a carry out of bits 15:8 ripples into bits 23:16.
- R6: Advancing from 0xFFFFFF wraps the pointer to 0x000000.
- R7: A data read with the pointer at or above the installed size (parameter MEM_BYTES) issues no `ram_re` and returns 0xFF. The pointer still advances.
- R8: A data write with the pointer at or above the installed size issues no `ram_we`. The pointer still advances.
- R9: When read and write strobes are both high in one cycle, only the write is performed. There is one RAM write, one increment, no RAM read, and `host_rdata` keeps its previous value.
- R10: `host_rdata` holds its last read result until the next accepted read, including across pointer writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 2 | Register select: 0 data, 1..3 pointer bytes low to high |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read result, valid from the cycle after the read |
| ram_addr | output | 24 | RAM byte address (current pointer) |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re`, held until the next read |

## Verification
Two functions can fall in one cycle: a data read and a data write. A sequential transfer can also be serviced in the same cycle that the pointer increment crosses a carry boundary or the installed-size limit. The bench raises both strobes together on the data register. It then judges the result on three points: a RAM write only, a pointer advanced by exactly one, and an unchanged `host_rdata`. A later read-back confirms the stored byte. The size-limit crossing is provoked by streaming from the last installed byte into the first missing one. The bench checks that the first access reaches the RAM and the second returns 0xFF with no enable.

// File: rtl/indmem_pkg.sv
package indmem_pkg;
   localparam int BYTE_W   = 8;
   localparam int REG_DATA = 0;
   localparam logic [BYTE_W-1:0] OOB_FILL = 8'hFF;
endpackage

// File: rtl/indmem_ptr.sv
module indmem_ptr import indmem_pkg::*; #(
   parameter int ADDR_W = 24,
   localparam int NB = ADDR_W / BYTE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [NB-1:0]     load,
   input  logic [BYTE_W-1:0] wdata,
   output logic [ADDR_W-1:0] ptr
);
   logic [NB-1:0] bump;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [BYTE_W-1:0] q;
      if (i == 0) begin : g_low
         assign bump[i] = step;
      end else begin : g_up
         assign bump[i] = step && (&ptr[i*BYTE_W-1:0]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= '0;
         else if (load[i])  q <= wdata;
         else if (bump[i])  q <= q + 1'b1;
      end
      assign ptr[i*BYTE_W +: BYTE_W] = q;
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ptr == $past(ptr) + 1'b1);                          // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && load == '0) |=> $stable(ptr));                     // R2
   AST_STEP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> load == '0);                                        // R2
endmodule

// File: rtl/indmem_range.sv
module indmem_range #(
   parameter int ADDR_W = 24,
   parameter longint unsigned MEM_BYTES = 64'd16777216
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              in_range
);
   localparam longint unsigned SPAN = 64'd1 << ADDR_W;

   if (MEM_BYTES >= SPAN) begin : g_full
      logic unused_addr;
      assign unused_addr = ^addr;
      assign in_range    = 1'b1;
   end else begin : g_part
      assign in_range = ({{(64-ADDR_W){1'b0}}, addr} < MEM_BYTES);
   end
endmodule

// File: rtl/indmem_rdback.sv
module indmem_rdback import indmem_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              cap_data,
   input  logic              cap_oob,
   input  logic [BYTE_W-1:0] ptr_byte,
   input  logic [BYTE_W-1:0] ram_rdata,
   output logic [BYTE_W-1:0] host_rdata
);
   logic              src_data_q;
   logic              oob_q;
   logic [BYTE_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_data_q <= 1'b0;
         oob_q      <= 1'b0;
         snap_q     <= '0;
      end else if (cap) begin
         src_data_q <= cap_data;
         oob_q      <= cap_oob;
         snap_q     <= ptr_byte;
      end
   end

   always_comb begin
      if (!src_data_q)  host_rdata = snap_q;
      else if (oob_q)   host_rdata = OOB_FILL;
      else              host_rdata = ram_rdata;
   end
endmodule

// File: rtl/indmem_port.sv
module indmem_port import indmem_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter longint unsigned MEM_BYTES = 64'd16777216,
   localparam int PTR_BYTES = ADDR_W / BYTE_W,
   localparam int SEL_W = $clog2(PTR_BYTES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic [BYTE_W-1:0] ram_wdata,
   input  logic [BYTE_W-1:0] ram_rdata
);
   if (ADDR_W % BYTE_W != 0 || ADDR_W < BYTE_W || ADDR_W > 56) begin : g_bad_width
      $error("indmem_port: ADDR_W must be a whole number of bytes, 8 to 56");
   end
   if (MEM_BYTES == 0) begin : g_bad_size
      $error("indmem_port: MEM_BYTES must be nonzero");
   end

   logic [ADDR_W-1:0]    ptr;
   logic                 in_range;
   logic                 data_sel;
   logic                 do_wr;
   logic                 do_rd;
   logic                 step;
   logic                 cap;
   logic [PTR_BYTES-1:0] load;
   logic [BYTE_W-1:0]    sel_byte;

   assign data_sel = (host_sel == SEL_W'(REG_DATA));
   assign do_wr    = host_wr && data_sel;
   assign do_rd    = host_rd && !host_wr && data_sel;
   assign step     = do_wr || do_rd;
   assign cap      = host_rd && !host_wr;

   for (genvar i = 0; i < PTR_BYTES; i++) begin : g_load
      assign load[i] = host_wr && (host_sel == SEL_W'(i + 1));
   end

   always_comb begin
      sel_byte = '0;
      for (int i = 0; i < PTR_BYTES; i++) begin
         if (host_sel == SEL_W'(i + 1)) sel_byte = ptr[i*BYTE_W +: BYTE_W];
      end
   end

   indmem_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .load  (load),
      .wdata (host_wdata),
      .ptr   (ptr)
   );

   indmem_range #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_range (
      .addr     (ptr),
      .in_range (in_range)
   );

   indmem_rdback u_rdback (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .cap_data   (data_sel),
      .cap_oob    (!in_range),
      .ptr_byte   (sel_byte),
      .ram_rdata  (ram_rdata),
      .host_rdata (host_rdata)
   );

   assign ram_addr  = ptr;
   assign ram_wdata = host_wdata;
   assign ram_we    = do_wr && in_range;
   assign ram_re    = do_rd && in_range;

   AST_EXCL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));                                        // R9
   AST_OOB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> in_range);                                        // R8
   AST_OOB_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && data_sel && !in_range) |=> host_rdata == OOB_FILL); // R7
   AST_BOTH_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_wr) |=> $stable(host_rdata));               // R9
endmodule

// File: tb/indmem_port_tb.sv
module indmem_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MEMSZ = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_sel = '0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [23:0] ram_addr;
   logic        ram_re;
   logic        ram_we;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int bad_we  = 0;
   int bad_re  = 0;
   logic [7:0] mem [0:MEMSZ-1];

   always #(CLK_PERIOD/2) clk = ~clk;

   indmem_port #(.ADDR_W(24), .MEM_BYTES(64'd1024)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   always @(posedge clk) begin
      if (ram_we) begin
         if (ram_addr < MEMSZ) mem[ram_addr[9:0]] <= ram_wdata;
         else bad_we++;
      end
      if (ram_re) begin
         if (ram_addr < MEMSZ) ram_rdata <= mem[ram_addr[9:0]];
         else bad_re++;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [1:0] s, logic [7:0] d);
      @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [1:0] s, output logic [7:0] d);
      @(negedge clk); host_sel = s; host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0; d = host_rdata;
   endtask

   task automatic set_ptr(logic [23:0] a);
      wr_reg(2'd1, a[7:0]); wr_reg(2'd2, a[15:8]); wr_reg(2'd3, a[23:16]);
   endtask

   task automatic get_ptr(output logic [23:0] a);
      logic [7:0] b;
      rd_reg(2'd1, b); a[7:0] = b;
      rd_reg(2'd2, b); a[15:8] = b;
      rd_reg(2'd3, b); a[23:16] = b;
   endtask

   task automatic t_reset;
      logic [23:0] p;
      chk("R1 rdata after reset", host_rdata, 8'h00);
      get_ptr(p);
      chk("R1 pointer after reset", p, 24'h0);
   endtask

   task automatic t_ptr_regs;
      logic [23:0] p;
      set_ptr(24'h123456);
      get_ptr(p);
      chk("R2 pointer load/readback", p, 24'h123456);
      wr_reg(2'd1, 8'hAB);
      get_ptr(p);
      chk("R2 low byte only", p, 24'h1234AB);
      wr_reg(2'd3, 8'h00);
      get_ptr(p);
      chk("R2 high byte only", p, 24'h0034AB);
   endtask

   task automatic t_write_seq;
      logic [23:0] p;
      set_ptr(24'h000040);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); host_sel = 2'd0; host_wdata = 8'h10 + 8'(k); host_wr = 1'b1;
         #1;
         chk("R3 ram_we", ram_we, 1'b1);
         chk("R3 ram_addr", ram_addr, 24'h40 + 24'(k));
         chk("R3 ram_wdata", ram_wdata, 8'h10 + 8'(k));
         @(negedge clk); host_wr = 1'b0;
      end
      get_ptr(p);
      chk("R3 pointer advanced", p, 24'h000044);
   endtask

   task automatic t_read_seq;
      logic [23:0] p;
      logic [7:0]  d;
      set_ptr(24'h000040);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); host_sel = 2'd0; host_rd = 1'b1;
         #1;
         chk("R4 ram_re", ram_re, 1'b1);
         chk("R4 ram_addr", ram_addr, 24'h40 + 24'(k));
         @(negedge clk); host_rd = 1'b0;
         chk("R4 read data", host_rdata, 8'h10 + 8'(k));
      end
      get_ptr(p);
      chk("R4 pointer advanced", p, 24'h000044);
      rd_reg(2'd0, d);
      repeat (3) @(negedge clk);
      wr_reg(2'd1, 8'h41);
      wr_reg(2'd2, 8'h00);
      chk("R10 rdata held", host_rdata, d);
   endtask

   task automatic t_carry;
      logic [23:0] p;
      logic [7:0]  d;
      set_ptr(24'h0000FF);
      wr_reg(2'd0, 8'h77);
      get_ptr(p);
      chk("R5 carry into middle", p, 24'h000100);
      set_ptr(24'h0000FF);
      rd_reg(2'd0, d);
      chk("R5 byte at 0xFF", d, 8'h77);
      set_ptr(24'h00FFFF);
      wr_reg(2'd0, 8'h01);
      get_ptr(p);
      chk("R5 carry into high", p, 24'h010000);
   endtask

   task automatic t_wrap;
      logic [23:0] p;
      logic [7:0]  d;
      set_ptr(24'hFFFFFF);
      rd_reg(2'd0, d);
      chk("R7 read beyond size", d, 8'hFF);
      get_ptr(p);
      chk("R6 wrap to zero", p, 24'h000000);
   endtask

   task automatic t_oob;
      logic [23:0] p;
      logic [7:0]  d;
      set_ptr(24'h0003FF);
      wr_reg(2'd0, 8'h21);
      @(negedge clk); host_sel = 2'd0; host_wdata = 8'h99; host_wr = 1'b1;
      #1;
      chk("R8 no ram_we beyond size", ram_we, 1'b0);
      @(negedge clk); host_wr = 1'b0;
      get_ptr(p);
      chk("R8 pointer still advances", p, 24'h000401);
      set_ptr(24'h0003FF);
      rd_reg(2'd0, d);
      chk("R8 last byte intact", d, 8'h21);
      @(negedge clk); host_sel = 2'd0; host_rd = 1'b1;
      #1;
      chk("R7 no ram_re beyond size", ram_re, 1'b0);
      @(negedge clk); host_rd = 1'b0;
      chk("R7 fill value", host_rdata, 8'hFF);
      chk("R8 no RAM cycle out of range", bad_we + bad_re, 0);
   endtask

   task automatic t_collide;
      logic [23:0] p;
      logic [7:0]  d;
      set_ptr(24'h000040);
      rd_reg(2'd0, d);
      chk("R9 setup read", d, 8'h10);
      set_ptr(24'h000060);
      @(negedge clk); host_sel = 2'd0; host_wdata = 8'h5A; host_rd = 1'b1; host_wr = 1'b1;
      #1;
      chk("R9 write performed", ram_we, 1'b1);
      chk("R9 read suppressed", ram_re, 1'b0);
      @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
      chk("R9 rdata unchanged", host_rdata, 8'h10);
      get_ptr(p);
      chk("R9 single increment", p, 24'h000061);
      set_ptr(24'h000060);
      rd_reg(2'd0, d);
      chk("R9 stored byte", d, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ptr_regs();
      t_write_seq();
      t_read_seq();
      t_carry();
      t_wrap();
      t_oob();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule